// File: doc/BRIEF.md
# Packet Command Phase Sequencer

This block is the host-side control for one packet command on a storage device interface. Software, or a higher-level engine, issues a start request with the command's direction and whether the data moves by DMA. Each time the device raises an interrupt, the block reads the status byte and the interrupt-reason bits and reduces them to a three-bit event. The pair (current phase, event) selects an action and a next phase from two independent tables.

The results are single-cycle strobes to the surrounding logic: send the command packet, start DMA, move one burst of data in or out, and complete the command with or without an error. Warning and error pulses report device misbehaviour. Two tolerance paths keep the command moving instead of failing it:
- a device that reports the wrong reason code in the status phase;
- a DRQ bit that drops between data bursts.

Each warning pulses only once until the next reset. When an interrupt arrives during DMA, the block first holds a halt request to the DMA engine until the engine acknowledges it. Only after that does it clear the interrupt and evaluate the event. Register bus timing, the data movers and the DMA engine are outside the block.

Top module: `pkt_phase_seq`

## Requirements
- R1: A synchronous active-high reset sets the phase to Idle (code 0) and clears all strobes. It also re-arms both one-time warnings, so each can pulse once more after reset.
- R2: `start_i` is accepted only in Idle. It moves the phase to Cmd (code 1), latches the direction and DMA flags, and pulses `start_ack_o`. In any other phase, `start_busy_o` pulses and the phase is unchanged.
- R3: The event is {IO, CoD, DRQ}, with IO = `rsn_i[1]`, CoD = `rsn_i[0]` and DRQ = `sts_i[3]`. The codes are:
  - 1: data to device
  - 2: idle
  - 3: packet request
  - 5: data from device
  - 6: status
  - 0 and 4: invalid
  - 7: reserved
- R4: In Cmd, event 3 pulses `send_pkt_o` and moves to Cdb (code 2). If the command uses DMA, `dma_go_o` also pulses and the phase becomes DmaActive (code 5).
- R5: Event 6 in any non-idle phase pulses `done_o` and returns to Idle. `done_err_o` pulses with it when device-fault `sts_i[5]` or error `sts_i[0]` is set.
- R6: Event 0 in Cdb, DataIn, DataOut or DmaActive completes the command as in R5. The first such completion after reset also pulses `rsn_warn_o`.
- R7: Events 2 and 4 in DataIn (code 3) or DataOut (code 4), and event 4 in Cdb, keep the phase. The first such event after reset pulses `drq_warn_o`.
- R8: With busy `sts_i[7]` set, an interrupt gives no action strobe and keeps the phase. `clr_intr_o` still pulses.
- R9: In DmaActive, an interrupt raises `dma_halt_o` and holds it until `dma_halt_ack_i`. `clr_intr_o` pulses only after the halt drops, and any event other than 0 or 6 then keeps DmaActive and pulses `unsup_o`.
- R10: Data events behave as follows:
  - Event 5 in Cdb moves to DataIn, and in DataIn stays.
  - Event 1 in Cdb moves to DataOut, and in DataOut stays.
  - `xfer_in_o` pulses only for a read command and `xfer_out_o` only for a write command.
  - Otherwise `proto_err_o` pulses with no transfer.
- R11: An undefined entry keeps the phase and pulses `unsup_o`. Examples are event 1 or 3 in DataIn, event 3 or 5 in DataOut, event 7 in any active phase, and all of the DmaActive cases of R9.
- R12: The remaining entries move the phase without an action:
  - In Cmd, events 0, 1, 2, 4 and 5 move to Cdb with no strobe.
  - In Cdb, events 2 and 3 change nothing.
  - An interrupt in Idle has no effect.
- R13: Every strobe appears in the cycle after the clock edge that samples `irq_i`, or after the edge that samples `dma_halt_ack_i` on the DMA path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request for a new command |
| cmd_rd_i | input | 1 | Command reads from the device |
| cmd_wr_i | input | 1 | Command writes to the device |
| cmd_dma_i | input | 1 | Command moves its data by DMA |
| start_ack_o | output | 1 | Start accepted |
| start_busy_o | output | 1 | Start refused, command in progress |
| irq_i | input | 1 | Device interrupt to service |
| sts_i | input | STS_W | Device status byte |
| rsn_i | input | RSN_W | Interrupt-reason bits |
| clr_intr_o | output | 1 | Read status and clear the interrupt latch |
| dma_halt_o | output | 1 | Halt request to the DMA engine |
| dma_halt_ack_i | input | 1 | DMA engine has halted |
| send_pkt_o | output | 1 | Send the command packet |
| dma_go_o | output | 1 | Start the DMA engine |
| xfer_in_o | output | 1 | Move one data burst from the device |
| xfer_out_o | output | 1 | Move one data burst to the device |
| done_o | output | 1 | Command complete |
| done_err_o | output | 1 | Completion carries a device error |
| proto_err_o | output | 1 | Data phase against command direction |
| drq_warn_o | output | 1 | First dropped-DRQ event since reset |
| rsn_warn_o | output | 1 | First wrong status reason since reset |
| unsup_o | output | 1 | Undefined table entry |
| phase_o | output | 3 | Current phase code |

## Verification
A read command, a write command and a DMA command each run through their full phase sequence. Together they separate the packet, transfer and completion paths, and show whether the DMA flag reroutes Cdb to DmaActive. Repeated tolerance events, given before and after a reset, show whether the warnings are one-time and re-armed. Status with busy set, a data phase against the command direction, reserved and undefined codes, and interrupts while idle each show a case where the phase must hold or the strobe must be withheld. On the DMA path, an acknowledge that is held back for an extra cycle shows the halt-before-clear ordering.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CMD  = 3'd1,
      PH_CDB  = 3'd2,
      PH_DIN  = 3'd3,
      PH_DOUT = 3'd4,
      PH_DMA  = 3'd5,
      PH_NONE = 3'd7   // table marker: keep the present phase
   } phase_t;

   typedef enum logic [2:0] {
      AC_NONE, AC_PKT, AC_IN, AC_OUT, AC_DRQ, AC_STAT, AC_STATX, AC_UNK
   } act_t;

   localparam int EV_W = 3;
endpackage

// File: rtl/pps_event_enc.sv
`timescale 1ns/1ps
module pps_event_enc #(
   parameter int STS_W   = 8,
   parameter int RSN_W   = 2,
   parameter int BSY_POS = 7,
   parameter int DF_POS  = 5,
   parameter int DRQ_POS = 3,
   parameter int ERR_POS = 0,
   parameter int COD_POS = 0,
   parameter int IO_POS  = 1
) (
   input  logic [STS_W-1:0] sts_i,
   input  logic [RSN_W-1:0] rsn_i,
   output logic [2:0]       ev_o,
   output logic             bsy_o,
   output logic             flt_o
);
   // R3: event = {IO, CoD, DRQ}
   assign ev_o  = {rsn_i[IO_POS], rsn_i[COD_POS], sts_i[DRQ_POS]};
   assign bsy_o = sts_i[BSY_POS];
   assign flt_o = sts_i[DF_POS] | sts_i[ERR_POS];

   logic unused_bits;
   assign unused_bits = ^{sts_i, rsn_i};
endmodule

// File: rtl/pps_tables.sv
`timescale 1ns/1ps
module pps_tables
   import pps_pkg::*;
(
   input  phase_t     st_i,
   input  logic [2:0] ev_i,
   output act_t       act_o,
   output phase_t     nxt_o
);
   always_comb begin
      act_o = AC_UNK;
      nxt_o = PH_NONE;
      case (st_i)
         PH_IDLE: begin act_o = AC_NONE; nxt_o = PH_IDLE; end
         PH_CMD: case (ev_i)
            3'd3:    begin act_o = AC_PKT;  nxt_o = PH_CDB;  end
            3'd6:    begin act_o = AC_STAT; nxt_o = PH_IDLE; end
            3'd7:    begin act_o = AC_NONE; nxt_o = PH_NONE; end
            default: begin act_o = AC_NONE; nxt_o = PH_CDB;  end
         endcase
         PH_CDB: case (ev_i)
            3'd0:    begin act_o = AC_STATX; nxt_o = PH_IDLE; end
            3'd1:    begin act_o = AC_OUT;   nxt_o = PH_DOUT; end
            3'd2,
            3'd3:    begin act_o = AC_NONE;  nxt_o = PH_CDB;  end
            3'd4:    begin act_o = AC_DRQ;   nxt_o = PH_CDB;  end
            3'd5:    begin act_o = AC_IN;    nxt_o = PH_DIN;  end
            3'd6:    begin act_o = AC_STAT;  nxt_o = PH_IDLE; end
            default: begin act_o = AC_UNK;   nxt_o = PH_NONE; end
         endcase
         PH_DIN: case (ev_i)
            3'd0:       begin act_o = AC_STATX; nxt_o = PH_IDLE; end
            3'd2, 3'd4: begin act_o = AC_DRQ;   nxt_o = PH_DIN;  end
            3'd5:       begin act_o = AC_IN;    nxt_o = PH_DIN;  end
            3'd6:       begin act_o = AC_STAT;  nxt_o = PH_IDLE; end
            default:    begin act_o = AC_UNK;   nxt_o = PH_NONE; end
         endcase
         PH_DOUT: case (ev_i)
            3'd0:       begin act_o = AC_STATX; nxt_o = PH_IDLE; end
            3'd1:       begin act_o = AC_OUT;   nxt_o = PH_DOUT; end
            3'd2, 3'd4: begin act_o = AC_DRQ;   nxt_o = PH_DOUT; end
            3'd6:       begin act_o = AC_STAT;  nxt_o = PH_IDLE; end
            default:    begin act_o = AC_UNK;   nxt_o = PH_NONE; end
         endcase
         PH_DMA: case (ev_i)
            3'd0:    begin act_o = AC_STATX; nxt_o = PH_IDLE; end
            3'd6:    begin act_o = AC_STAT;  nxt_o = PH_IDLE; end
            default: begin act_o = AC_UNK;   nxt_o = PH_DMA;  end
         endcase
         default: begin act_o = AC_UNK; nxt_o = PH_NONE; end
      endcase
   end
endmodule

// File: rtl/pps_once.sv
`timescale 1ns/1ps
module pps_once (
   input  logic clk,
   input  logic rst,
   input  logic hit_i,
   output logic first_o
);
   logic seen_q;
   assign first_o = hit_i & ~seen_q;
   always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b0;
      else if (hit_i) seen_q <= 1'b1;
   end
endmodule

// File: rtl/pkt_phase_seq.sv
`timescale 1ns/1ps
module pkt_phase_seq
   import pps_pkg::*;
#(
   parameter int STS_W   = 8,
   parameter int RSN_W   = 2,
   parameter int BSY_POS = 7,
   parameter int DF_POS  = 5,
   parameter int DRQ_POS = 3,
   parameter int ERR_POS = 0,
   parameter int COD_POS = 0,
   parameter int IO_POS  = 1,
   parameter bit DMA_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             cmd_rd_i,
   input  logic             cmd_wr_i,
   input  logic             cmd_dma_i,
   output logic             start_ack_o,
   output logic             start_busy_o,
   input  logic             irq_i,
   input  logic [STS_W-1:0] sts_i,
   input  logic [RSN_W-1:0] rsn_i,
   output logic             clr_intr_o,
   output logic             dma_halt_o,
   input  logic             dma_halt_ack_i,
   output logic             send_pkt_o,
   output logic             dma_go_o,
   output logic             xfer_in_o,
   output logic             xfer_out_o,
   output logic             done_o,
   output logic             done_err_o,
   output logic             proto_err_o,
   output logic             drq_warn_o,
   output logic             rsn_warn_o,
   output logic             unsup_o,
   output logic [EV_W-1:0]  phase_o
);
   localparam int NWARN = 2;

   if (BSY_POS >= STS_W || DF_POS >= STS_W || DRQ_POS >= STS_W || ERR_POS >= STS_W)
   begin : g_bad_sts
      $error("status bit position outside STS_W");
   end
   if (COD_POS >= RSN_W || IO_POS >= RSN_W || COD_POS == IO_POS) begin : g_bad_rsn
      $error("reason bit positions invalid");
   end

   phase_t     st_q, tbl_nxt, nxt;
   act_t       tbl_act;
   logic [2:0] ev;
   logic       bsy, flt;
   logic       pend_q, rd_q, wr_q, dma_q, dma_sel;
   logic       direct, halt_req, eval, fire, start_ok;
   logic       send_d, go_d, xin_d, xout_d, done_d, derr_d, perr_d, unsup_d;
   logic [NWARN-1:0] warn_hit, warn_first;

   pps_event_enc #(
      .STS_W(STS_W), .RSN_W(RSN_W), .BSY_POS(BSY_POS), .DF_POS(DF_POS),
      .DRQ_POS(DRQ_POS), .ERR_POS(ERR_POS), .COD_POS(COD_POS), .IO_POS(IO_POS)
   ) u_enc (
      .sts_i(sts_i), .rsn_i(rsn_i), .ev_o(ev), .bsy_o(bsy), .flt_o(flt)
   );

   pps_tables u_tbl (.st_i(st_q), .ev_i(ev), .act_o(tbl_act), .nxt_o(tbl_nxt));

   for (genvar w = 0; w < NWARN; w++) begin : g_warn
      pps_once u_once (.clk(clk), .rst(rst), .hit_i(warn_hit[w]), .first_o(warn_first[w]));
   end

   if (DMA_EN) begin : g_dma
      assign dma_sel = cmd_dma_i;
   end else begin : g_nodma
      assign dma_sel = 1'b0;
   end

   assign direct   = irq_i && !pend_q && st_q != PH_DMA;
   assign halt_req = irq_i && !pend_q && st_q == PH_DMA;
   assign eval     = direct || (pend_q && dma_halt_ack_i);
   assign fire     = eval && !bsy;
   assign start_ok = start_i && st_q == PH_IDLE;

   always_comb begin
      nxt = st_q;
      {send_d, go_d, xin_d, xout_d, done_d, derr_d, perr_d, unsup_d} = '0;
      warn_hit = '0;
      if (fire) begin
         if (tbl_nxt != PH_NONE) nxt = tbl_nxt;
         else unsup_d = 1'b1;
         case (tbl_act)
            AC_PKT: begin
               send_d = 1'b1;
               if (dma_q) begin go_d = 1'b1; nxt = PH_DMA; end
            end
            AC_IN:    if (rd_q) xin_d  = !dma_q; else perr_d = 1'b1;
            AC_OUT:   if (wr_q) xout_d = !dma_q; else perr_d = 1'b1;
            AC_DRQ:   warn_hit[0] = 1'b1;
            AC_STAT:  begin done_d = 1'b1; derr_d = flt; end
            AC_STATX: begin done_d = 1'b1; derr_d = flt; warn_hit[1] = 1'b1; end
            AC_UNK:   unsup_d = 1'b1;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= PH_IDLE;
         pend_q <= 1'b0;
         rd_q   <= 1'b0;
         wr_q   <= 1'b0;
         dma_q  <= 1'b0;
         {start_ack_o, start_busy_o, clr_intr_o} <= '0;
         {send_pkt_o, dma_go_o, xfer_in_o, xfer_out_o, done_o, done_err_o} <= '0;
         {proto_err_o, drq_warn_o, rsn_warn_o, unsup_o} <= '0;
      end else begin
         if (start_ok) begin
            st_q  <= PH_CMD;
            rd_q  <= cmd_rd_i;
            wr_q  <= cmd_wr_i;
            dma_q <= dma_sel;
         end else if (fire) begin
            st_q <= nxt;
         end
         if (halt_req) pend_q <= 1'b1;
         else if (pend_q && dma_halt_ack_i) pend_q <= 1'b0;
         start_ack_o  <= start_ok;
         start_busy_o <= start_i && !start_ok;
         clr_intr_o   <= eval;
         send_pkt_o   <= send_d;
         dma_go_o     <= go_d;
         xfer_in_o    <= xin_d;
         xfer_out_o   <= xout_d;
         done_o       <= done_d;
         done_err_o   <= derr_d;
         proto_err_o  <= perr_d;
         drq_warn_o   <= warn_first[0];
         rsn_warn_o   <= warn_first[1];
         unsup_o      <= unsup_d;
      end
   end

   assign dma_halt_o = pend_q;
   assign phase_o    = st_q;
endmodule

// File: rtl/pps_checker.sv
`timescale 1ns/1ps
module pps_checker
   import pps_pkg::*;
#(
   parameter int STS_W   = 8,
   parameter int BSY_POS = 7
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic             irq_i,
   input logic [STS_W-1:0] sts_i,
   input logic             start_ack_o,
   input logic             clr_intr_o,
   input logic             dma_halt_o,
   input logic             send_pkt_o,
   input logic             xfer_in_o,
   input logic             xfer_out_o,
   input logic             done_o,
   input logic             drq_warn_o,
   input logic             rsn_warn_o,
   input logic             unsup_o,
   input logic [2:0]       phase_o
);
   logic drq_seen, rsn_seen;
   always_ff @(posedge clk) begin
      if (rst) begin
         drq_seen <= 1'b0;
         rsn_seen <= 1'b0;
      end else begin
         if (drq_warn_o) drq_seen <= 1'b1;
         if (rsn_warn_o) rsn_seen <= 1'b1;
      end
   end

   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
      start_ack_o |-> (phase_o == PH_CMD && $past(phase_o) == PH_IDLE)); // R2
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      done_o |-> phase_o == PH_IDLE); // R5
   AST_RSN_WARN_ONCE: assert property (@(posedge clk) disable iff (rst)
      rsn_warn_o |-> !rsn_seen); // R6
   AST_DRQ_WARN_ONCE: assert property (@(posedge clk) disable iff (rst)
      drq_warn_o |-> !drq_seen); // R7
   AST_BUSY_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
      (irq_i && !dma_halt_o && phase_o != PH_DMA && sts_i[BSY_POS] && !start_i)
      |=> ($stable(phase_o) && !done_o && !send_pkt_o && !xfer_in_o && !xfer_out_o)); // R8
   AST_HALT_BEFORE_CLEAR: assert property (@(posedge clk) disable iff (rst)
      dma_halt_o |-> !clr_intr_o); // R9
   AST_DMA_CLEAR_AFTER_HALT: assert property (@(posedge clk) disable iff (rst)
      (clr_intr_o && phase_o == PH_DMA && $past(phase_o) == PH_DMA) |-> $past(dma_halt_o)); // R9
   AST_XFER_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
      xfer_in_o |-> phase_o == PH_DIN); // R10
   AST_XFER_OUT_PHASE: assert property (@(posedge clk) disable iff (rst)
      xfer_out_o |-> phase_o == PH_DOUT); // R10
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
      $onehot0({send_pkt_o, xfer_in_o, xfer_out_o, done_o, unsup_o})); // R11
endmodule

bind pkt_phase_seq pps_checker #(.STS_W(STS_W), .BSY_POS(BSY_POS)) u_pps_chk (
   .clk(clk), .rst(rst), .start_i(start_i), .irq_i(irq_i), .sts_i(sts_i),
   .start_ack_o(start_ack_o), .clr_intr_o(clr_intr_o), .dma_halt_o(dma_halt_o),
   .send_pkt_o(send_pkt_o), .xfer_in_o(xfer_in_o), .xfer_out_o(xfer_out_o),
   .done_o(done_o), .drq_warn_o(drq_warn_o), .rsn_warn_o(rsn_warn_o),
   .unsup_o(unsup_o), .phase_o(phase_o)
);

// File: tb/test_pkt_phase_seq.sv
`timescale 1ns/1ps
module test_pkt_phase_seq;
   localparam logic [9:0] B_SEND = 10'h200, B_GO = 10'h100, B_XIN = 10'h080,
                          B_XOUT = 10'h040, B_DONE = 10'h020, B_DERR = 10'h010,
                          B_PERR = 10'h008, B_DWARN = 10'h004, B_RWARN = 10'h002,
                          B_UNSUP = 10'h001;

   logic clk = 1'b0, rst = 1'b1;
   logic start_i = 0, cmd_rd_i = 0, cmd_wr_i = 0, cmd_dma_i = 0;
   logic irq_i = 0, dma_halt_ack_i = 0;
   logic [7:0] sts_i = '0;
   logic [1:0] rsn_i = '0;
   logic start_ack_o, start_busy_o, clr_intr_o, dma_halt_o;
   logic send_pkt_o, dma_go_o, xfer_in_o, xfer_out_o, done_o, done_err_o;
   logic proto_err_o, drq_warn_o, rsn_warn_o, unsup_o;
   logic [2:0] phase_o;

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   logic [9:0] smp;
   logic smp_clr;

   always #2.5 clk = ~clk;

   pkt_phase_seq i_pkt_phase_seq (
      .clk(clk), .rst(rst), .start_i(start_i), .cmd_rd_i(cmd_rd_i),
      .cmd_wr_i(cmd_wr_i), .cmd_dma_i(cmd_dma_i), .start_ack_o(start_ack_o),
      .start_busy_o(start_busy_o), .irq_i(irq_i), .sts_i(sts_i), .rsn_i(rsn_i),
      .clr_intr_o(clr_intr_o), .dma_halt_o(dma_halt_o), .dma_halt_ack_i(dma_halt_ack_i),
      .send_pkt_o(send_pkt_o), .dma_go_o(dma_go_o), .xfer_in_o(xfer_in_o),
      .xfer_out_o(xfer_out_o), .done_o(done_o), .done_err_o(done_err_o),
      .proto_err_o(proto_err_o), .drq_warn_o(drq_warn_o), .rsn_warn_o(rsn_warn_o),
      .unsup_o(unsup_o), .phase_o(phase_o)
   );

   function automatic logic [9:0] bundle();
      return {send_pkt_o, dma_go_o, xfer_in_o, xfer_out_o, done_o, done_err_o,
              proto_err_o, drq_warn_o, rsn_warn_o, unsup_o};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_start(input logic rd, input logic wr, input logic dma);
      @(negedge clk);
      start_i = 1; cmd_rd_i = rd; cmd_wr_i = wr; cmd_dma_i = dma;
      @(posedge clk); @(negedge clk);
      start_i = 0;
   endtask

   // event code {io,cod,drq} (R3); status bits bsy=7 df=5 drq=3 err=0
   task automatic do_irq(input logic [2:0] evc, input logic bsy, input logic df, input logic err);
      @(negedge clk);
      irq_i = 1; rsn_i = evc[2:1];
      sts_i = {bsy, 1'b0, df, 1'b0, evc[0], 2'b00, err};
      @(posedge clk); @(negedge clk);
      smp = bundle(); smp_clr = clr_intr_o;
      irq_i = 0;
   endtask

   task automatic dma_irq(input logic [2:0] evc, input logic df);
      @(negedge clk);
      irq_i = 1; rsn_i = evc[2:1];
      sts_i = {1'b0, 1'b0, df, 1'b0, evc[0], 3'b000};
      @(posedge clk); @(negedge clk);
      irq_i = 0;
      chk("R9 halt raised", dma_halt_o, 1);
      chk("R9 no clear before halt", clr_intr_o, 0);
      chk("R9 no action while halting", bundle(), 0);
      @(posedge clk); @(negedge clk);
      chk("R9 halt held without ack", dma_halt_o, 1);
      dma_halt_ack_i = 1;
      @(posedge clk); @(negedge clk);
      dma_halt_ack_i = 0;
      smp = bundle(); smp_clr = clr_intr_o;
      chk("R9 halt dropped", dma_halt_o, 0);
      chk("R9 clear after halt", smp_clr, 1);
   endtask

   task automatic t_reset();
      chk("R1 reset phase", phase_o, 0);
      chk("R1 reset strobes", bundle(), 0);
      chk("R1 reset halt", dma_halt_o, 0);
   endtask

   task automatic t_start();
      do_start(1, 0, 0);
      chk("R2 start ack", start_ack_o, 1);
      chk("R2 start phase", phase_o, 1);
      do_start(0, 1, 0);
      chk("R2 busy refused", start_busy_o, 1);
      chk("R2 busy no ack", start_ack_o, 0);
      chk("R2 busy phase kept", phase_o, 1);
      do_irq(3'd7, 0, 0, 0);
      chk("R11 reserved in Cmd", smp, B_UNSUP);
      chk("R11 reserved keeps Cmd", phase_o, 1);
      do_irq(3'd6, 0, 0, 0);
      chk("R5 status from Cmd", smp, B_DONE);
      chk("R5 back to Idle", phase_o, 0);
   endtask

   task automatic t_pio_read();
      do_start(1, 0, 0);
      do_irq(3'd3, 0, 0, 0);
      chk("R4/R3 packet strobe", smp, B_SEND);
      chk("R4 phase Cdb", phase_o, 2);
      do_irq(3'd5, 0, 0, 0);
      chk("R10/R3 data in", smp, B_XIN);
      chk("R10 phase DataIn", phase_o, 3);
      do_irq(3'd5, 0, 0, 0);
      chk("R10 second burst", smp, B_XIN);
      do_irq(3'd2, 0, 0, 0);
      chk("R7 first drq warn", smp, B_DWARN);
      chk("R7 keeps DataIn", phase_o, 3);
      do_irq(3'd4, 0, 0, 0);
      chk("R7 warn only once", smp, 0);
      chk("R7 keeps DataIn again", phase_o, 3);
      do_irq(3'd1, 0, 0, 0);
      chk("R11 out event in DataIn", smp, B_UNSUP);
      chk("R11 keeps DataIn", phase_o, 3);
      do_irq(3'd6, 1, 0, 0);
      chk("R8 busy no action", smp, 0);
      chk("R8 busy clears intr", smp_clr, 1);
      chk("R8 busy keeps phase", phase_o, 3);
      do_irq(3'd6, 0, 0, 1);
      chk("R5/R13 status with err", smp, B_DONE | B_DERR);
      chk("R5 read done idle", phase_o, 0);
   endtask

   task automatic t_write_rsn();
      do_start(0, 1, 0);
      do_irq(3'd0, 0, 0, 0);
      chk("R12 invalid in Cmd", smp, 0);
      chk("R12 Cmd to Cdb", phase_o, 2);
      do_irq(3'd2, 0, 0, 0);
      chk("R12 idle in Cdb", smp, 0);
      chk("R12 stays Cdb", phase_o, 2);
      do_irq(3'd1, 0, 0, 0);
      chk("R10 data out", smp, B_XOUT);
      chk("R10 phase DataOut", phase_o, 4);
      do_irq(3'd0, 0, 0, 0);
      chk("R6 wrong reason done", smp, B_DONE | B_RWARN);
      chk("R6 to Idle", phase_o, 0);
      do_start(0, 1, 0);
      do_irq(3'd3, 0, 0, 0);
      do_irq(3'd1, 0, 0, 0);
      do_irq(3'd0, 0, 1, 0);
      chk("R6 reason warn once", smp, B_DONE | B_DERR);
   endtask

   task automatic t_dir_err();
      do_start(1, 0, 0);
      do_irq(3'd3, 0, 0, 0);
      do_irq(3'd1, 0, 0, 0);
      chk("R10 out on read", smp, B_PERR);
      chk("R10 phase still moves", phase_o, 4);
      do_irq(3'd6, 0, 1, 0);
      chk("R5 status with fault", smp, B_DONE | B_DERR);
   endtask

   task automatic t_dma();
      do_start(1, 0, 1);
      do_irq(3'd3, 0, 0, 0);
      chk("R4 dma packet", smp, B_SEND | B_GO);
      chk("R4 phase DmaActive", phase_o, 5);
      dma_irq(3'd5, 0);
      chk("R9 data event in dma", smp, B_UNSUP);
      chk("R9 keeps DmaActive", phase_o, 5);
      dma_irq(3'd6, 0);
      chk("R5 dma done", smp, B_DONE);
      chk("R5 dma to Idle", phase_o, 0);
   endtask

   task automatic t_idle_irq();
      do_irq(3'd5, 0, 0, 0);
      chk("R12 irq in Idle", smp, 0);
      chk("R12 Idle kept", phase_o, 0);
   endtask

   task automatic t_reset_rearm();
      @(negedge clk); rst = 1;
      @(posedge clk); @(negedge clk); rst = 0;
      chk("R1 phase after reset", phase_o, 0);
      do_start(1, 0, 0);
      do_irq(3'd3, 0, 0, 0);
      do_irq(3'd5, 0, 0, 0);
      do_irq(3'd2, 0, 0, 0);
      chk("R1 drq warn rearmed", smp, B_DWARN);
      do_irq(3'd0, 0, 0, 0);
      chk("R1 reason warn rearmed", smp, B_DONE | B_RWARN);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      t_reset();
      t_start();
      t_pio_read();
      t_write_rsn();
      t_dir_err();
      t_dma();
      t_idle_irq();
      t_reset_rearm();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule